// File: doc/BRIEF.md
# Color and Scroll RAM Access Port

This block sits between the host side of a tile-based video controller and two small on-chip memories: a color RAM holding 64 palette words and a vertical-scroll RAM holding 40 scroll words. Host writes do not go straight to memory. They enter a four-entry queue, and each queued entry is committed to its target memory on a clock in which the surrounding arbiter grants an access slot. Host reads are served directly from the memories through a shared access address. Each read strobe steps that address by a programmable step size.

The port copies several quirks that existing software may depend on. Bit positions that a memory does not implement are not returned as zero. They are filled from the stale data still held in the queue slot that the next push will overwrite. A scroll read beyond the last implemented entry returns entry 0. A scroll write beyond it is dropped. A queued entry flagged as a fill-DMA write stores that same stale slot data, not its own value.

Top module: `palette_scroll_port`

## Requirements
- R1: After a synchronous active-low reset, every memory word, every queue slot, both queue pointers and the access address are zero, so a read of either memory returns 0.
- R2: The queue holds up to 4 entries in a ring. On a clock with slot_free high and at least one entry queued, exactly one entry (the oldest) is committed. With slot_free low, or with the queue empty, nothing is committed. The read pointer wraps modulo 4.
- R3: A push on a clock when 4 entries are queued and no entry commits is dropped: no slot, pointer or memory changes.
- R4: A committed color entry (push_target = 0) writes word index (addr >> 1) & 63. Only the bits under mask 0x0EEE (bits 1–3, 5–7, 9–11) are stored.
- R5: A color read returns the stored bits under 0x0EEE. Every other bit comes from the data of the queue slot at the write pointer.
- R6: A committed scroll entry (push_target = 1) writes word index (addr >> 1) & 63 and keeps bits 0x07FF. When that index is 40 or more, the write is discarded and no scroll word changes.
- R7: A scroll read uses index (addr >> 1) & 63, or index 0 when that is 40 or more. It returns the stored bits under 0x07FF, and every other bit comes from the queue slot at the write pointer.
- R8: When a committed entry has its fill flag set, the data written is the data of the queue slot at the write pointer in the commit cycle, not the entry's own data. This applies to both memories.
- R9: Each rd_strobe without addr_load adds step_size, zero-extended, to the 16-bit access address. The sum wraps modulo 2^16.
- R10: addr_load sets the access address to addr_value on the next clock. It takes priority over a rd_strobe in the same cycle.
- R11: rd_data is combinational. It reflects the current access address, rd_target and stored state in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Queue a write entry this cycle |
| push_target | input | 1 | Entry target: 0 color RAM, 1 scroll RAM |
| push_addr | input | 16 | Entry byte address |
| push_data | input | 16 | Entry data |
| push_fill | input | 1 | Entry is a fill-DMA write |
| slot_free | input | 1 | Memory access slot granted; commit oldest entry if any |
| addr_load | input | 1 | Load the access address |
| addr_value | input | 16 | Value for addr_load |
| step_size | input | 8 | Address step added after each read |
| rd_strobe | input | 1 | Host read taken this cycle |
| rd_target | input | 1 | Read target: 0 color RAM, 1 scroll RAM |
| rd_data | output | 16 | Read data |

## Verification
The hardest case to reach is the fill write. Its stored value comes from the slot under the write pointer, which holds whatever was pushed four entries earlier, so it depends on the whole push history. The bench queues distinct data in every slot with slot_free held low. It then pushes the fill entry, so the slot it will reference holds a known older value, and drains. The dropped push on a full queue is reached the same way: slot_free is held low across a fifth push. Both cases are checked through later reads of the memories and through the stale upper bits.

// File: rtl/psp_pkg.sv
// Package psp_pkg
// Shared sizes, entry type and address/color helpers for the color and
// scroll RAM access port. Assumes byte addressing of 16-bit words.
package psp_pkg;

    localparam int ADDR_W       = 16;
    localparam int DATA_W       = 16;
    localparam int STEP_W       = 8;
    localparam int FIFO_DEPTH   = 4;
    localparam int IDX_W        = 6;
    localparam int CRAM_WORDS   = 64;
    localparam int CRAM_IDX_W   = $clog2(CRAM_WORDS);
    localparam int CHANNELS     = 3;
    localparam int CH_BITS      = 3;
    localparam int CH_STRIDE    = 4;
    localparam int CH_LSB       = 1;
    localparam int COLOR_BITS   = CHANNELS * CH_BITS;
    localparam int SCROLL_WORDS = 40;
    localparam int SCROLL_BITS  = 11;

    typedef enum logic {
        TGT_COLOR  = 1'b0,
        TGT_SCROLL = 1'b1
    } target_e;

    typedef struct packed {
        target_e             tgt;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic                fill;
    } entry_t;

    // Byte address to 6-bit word index.
    function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
        return a[IDX_W:1];
    endfunction

    // Gather the implemented color bits of a bus word into a dense field.
    function automatic logic [COLOR_BITS-1:0] color_pack(input logic [DATA_W-1:0] v);
        logic [COLOR_BITS-1:0] p;
        p = '0;
        for (int ch = 0; ch < CHANNELS; ch++)
            p[ch*CH_BITS +: CH_BITS] = v[ch*CH_STRIDE + CH_LSB +: CH_BITS];
        return p;
    endfunction

    // Spread a dense color field back to bus bit positions, zeros elsewhere.
    function automatic logic [DATA_W-1:0] color_unpack(input logic [COLOR_BITS-1:0] p);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int ch = 0; ch < CHANNELS; ch++)
            v[ch*CH_STRIDE + CH_LSB +: CH_BITS] = p[ch*CH_BITS +: CH_BITS];
        return v;
    endfunction

    localparam logic [DATA_W-1:0] COLOR_MASK  = color_unpack('1);
    localparam logic [DATA_W-1:0] SCROLL_MASK = DATA_W'((1 << SCROLL_BITS) - 1);

endpackage

// File: rtl/psp_entry_fifo.sv
// Module psp_entry_fifo
// Ring queue of write entries. Commits the oldest entry when the access
// slot is granted and the queue is not empty; drops a push when full and
// not committing. Exposes the data left in the slot under the write
// pointer, which other logic uses as stale fill data.
module psp_entry_fifo
    import psp_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  entry_t            push_entry,
    input  logic              pop_req,
    output logic              commit,
    output entry_t            head,
    output logic [DATA_W-1:0] stale_data
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    entry_t          slots [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [PW:0]     count;
    logic            accept;

    // Commit and accept decisions for this cycle.
    always_comb begin
        commit = pop_req && (count != '0);
        accept = push_valid && ((count != FULL_CNT) || commit);
    end

    assign head       = slots[rd_ptr];
    assign stale_data = slots[wr_ptr].data;

    // Slot storage: write accepted pushes at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (accept) begin
            slots[wr_ptr] <= push_entry;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + PW'(1);
            if (commit) rd_ptr <= rd_ptr + PW'(1);
            case ({accept, commit})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    commit_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && count != '0) |=> rd_ptr == $past(rd_ptr) + PW'(1));

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_req || count == '0) |=> $stable(rd_ptr));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !pop_req && count == FULL_CNT) |=> $stable(wr_ptr) && count == FULL_CNT);

endmodule

// File: rtl/psp_color_ram.sv
// Module psp_color_ram
// Color RAM of CRAM_WORDS words. Stores only the implemented color bits
// in dense form and returns them at bus positions with zeros elsewhere.
// Read is combinational; write is one per clock.
module psp_color_ram
    import psp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CRAM_IDX_W-1:0] widx,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [CRAM_IDX_W-1:0] ridx,
    output logic [DATA_W-1:0]     rdata
);

    logic [COLOR_BITS-1:0] mem [CRAM_WORDS];

    // Storage update: clear on reset, write packed color bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CRAM_WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= color_pack(wdata);
        end
    end

    assign rdata = color_unpack(mem[ridx]);

    // R4
    color_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (color_unpack(mem[$past(widx)]) == ($past(wdata) & COLOR_MASK)));

endmodule

// File: rtl/psp_scroll_ram.sv
// Module psp_scroll_ram
// Scroll RAM of SCROLL_WORDS words of SCROLL_BITS bits. Writes whose
// index is past the end are discarded; reads past the end return word 0.
module psp_scroll_ram
    import psp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(SCROLL_WORDS);

    logic [SCROLL_BITS-1:0] mem [SCROLL_WORDS];
    logic                   w_in_range;
    logic [IDX_W-1:0]       r_eff;

    // Range decode for write discard and read aliasing.
    always_comb begin
        w_in_range = (widx < LIMIT);
        r_eff      = (ridx < LIMIT) ? ridx : '0;
    end

    // Storage update: clear on reset, write only in-range indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SCROLL_WORDS; i++) mem[i] <= '0;
        end else if (we && w_in_range) begin
            mem[widx] <= wdata[SCROLL_BITS-1:0];
        end
    end

    assign rdata = DATA_W'(mem[r_eff]);

    // R6: an out-of-range write leaves every word untouched.
    for (genvar g = 0; g < SCROLL_WORDS; g++) begin : g_keep
        // R6
        discard_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx >= LIMIT) |=> $stable(mem[g]));
    end

endmodule

// File: rtl/psp_addr_ctr.sv
// Module psp_addr_ctr
// Shared 16-bit access address. A load takes priority; otherwise each
// read strobe adds the zero-extended step, wrapping modulo 2^16.
module psp_addr_ctr
    import psp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_value,
    input  logic              advance,
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr
);

    // Address register: load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_value;
        else if (advance)
            addr <= addr + ADDR_W'(step);
    end

    // R9
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> addr == $past(addr) + {{(ADDR_W-STEP_W){1'b0}}, $past(step)});

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(load_value));

endmodule

// File: rtl/palette_scroll_port.sv
// Module palette_scroll_port
// Host access port to the color and scroll RAMs. Queued writes are
// committed one per granted slot; fill entries store the stale slot data
// under the write pointer. Reads are combinational, fill unimplemented
// bits from that same stale data, and step the shared access address.
module palette_scroll_port
    import psp_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic              push_target,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_fill,
    input  logic              slot_free,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic [STEP_W-1:0] step_size,
    input  logic              rd_strobe,
    input  logic              rd_target,
    output logic [DATA_W-1:0] rd_data
);

    entry_t            in_entry;
    entry_t            head;
    logic              commit;
    logic [DATA_W-1:0] stale;
    logic [DATA_W-1:0] wr_value;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] acc_addr;
    logic              color_we;
    logic              scroll_we;
    logic [DATA_W-1:0] color_q;
    logic [DATA_W-1:0] scroll_q;

    // Bundle the incoming entry.
    always_comb begin
        in_entry.tgt  = target_e'(push_target);
        in_entry.addr = push_addr;
        in_entry.data = push_data;
        in_entry.fill = push_fill;
    end

    psp_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_entry (in_entry),
        .pop_req    (slot_free),
        .commit     (commit),
        .head       (head),
        .stale_data (stale)
    );

    // Commit decode: pick data source and steer the write to one memory.
    always_comb begin
        wr_value  = head.fill ? stale : head.data;
        wr_idx    = word_index(head.addr);
        color_we  = commit && (head.tgt == TGT_COLOR);
        scroll_we = commit && (head.tgt == TGT_SCROLL);
        rd_idx    = word_index(acc_addr);
    end

    psp_color_ram u_color (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (color_we),
        .widx  (wr_idx[CRAM_IDX_W-1:0]),
        .wdata (wr_value),
        .ridx  (rd_idx[CRAM_IDX_W-1:0]),
        .rdata (color_q)
    );

    psp_scroll_ram u_scroll (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (scroll_we),
        .widx  (wr_idx),
        .wdata (wr_value),
        .ridx  (rd_idx),
        .rdata (scroll_q)
    );

    psp_addr_ctr u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (addr_load),
        .load_value (addr_value),
        .advance    (rd_strobe),
        .step       (step_size),
        .addr       (acc_addr)
    );

    // Read data merge: implemented bits from memory, the rest stale.
    always_comb begin
        if (target_e'(rd_target) == TGT_COLOR)
            rd_data = (color_q & COLOR_MASK) | (stale & ~COLOR_MASK);
        else
            rd_data = (scroll_q & SCROLL_MASK) | (stale & ~SCROLL_MASK);
    end

endmodule

// File: tb/sim_palette_scroll_port.sv
`timescale 1ns/1ps
module sim_palette_scroll_port;

    localparam logic [15:0] CM = 16'h0EEE;
    localparam logic [15:0] SM = 16'h07FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_target = 1'b0;
    logic [15:0] push_addr = '0;
    logic [15:0] push_data = '0;
    logic        push_fill = 1'b0;
    logic        slot_free = 1'b0;
    logic        addr_load = 1'b0;
    logic [15:0] addr_value = '0;
    logic [7:0]  step_size = '0;
    logic        rd_strobe = 1'b0;
    logic        rd_target = 1'b0;
    logic [15:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Requirement model
    logic [15:0] m_c [64];
    logic [15:0] m_s [40];
    logic [15:0] m_d [4];
    logic [15:0] m_a [4];
    bit          m_t [4];
    bit          m_f [4];
    int          m_wp = 0, m_rp = 0, m_cnt = 0;
    logic [15:0] m_addr = '0;

    palette_scroll_port u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the given controls; model follows the requirements.
    task automatic cyc(input bit pv, input bit tg, input logic [15:0] a, input logic [15:0] d,
                       input bit f, input bit go, input bit ld, input logic [15:0] lv,
                       input bit strobe, input bit rtg);
        bit com;
        logic [15:0] val;
        int idx;
        push_valid = pv; push_target = tg; push_addr = a; push_data = d; push_fill = f;
        slot_free = go; addr_load = ld; addr_value = lv; rd_strobe = strobe; rd_target = rtg;
        com = go && (m_cnt > 0);
        if (com) begin
            val = m_f[m_rp] ? m_d[m_wp] : m_d[m_rp];
            idx = int'((m_a[m_rp] >> 1) & 16'h3F);
            if (!m_t[m_rp]) m_c[idx] = val & CM;
            else if (idx < 40) m_s[idx] = val & SM;
            m_rp = (m_rp + 1) % 4;
            m_cnt--;
        end
        if (pv && (m_cnt < 4)) begin
            m_d[m_wp] = d; m_a[m_wp] = a; m_t[m_wp] = tg; m_f[m_wp] = f;
            m_wp = (m_wp + 1) % 4;
            m_cnt++;
        end
        if (ld) m_addr = lv;
        else if (strobe) m_addr = m_addr + {8'h00, step_size};
        @(negedge clk);
        push_valid = 0; slot_free = 0; addr_load = 0; rd_strobe = 0;
    endtask

    task automatic push(input bit tg, input logic [15:0] a, input logic [15:0] d, input bit f, input bit go);
        cyc(1, tg, a, d, f, go, 0, '0, 0, rd_target);
    endtask

    task automatic drain();
        while (m_cnt > 0) cyc(0, 0, '0, '0, 0, 1, 0, '0, 0, rd_target);
    endtask

    task automatic load(input logic [15:0] a);
        cyc(0, 0, '0, '0, 0, 0, 1, a, 0, rd_target);
    endtask

    // Check rd_data at the current address, then take the read strobe.
    task automatic rd_chk(input bit tg, input string req);
        int idx;
        logic [15:0] exp;
        rd_target = tg;
        #0.5;
        idx = int'((m_addr >> 1) & 16'h3F);
        if (!tg) exp = (m_c[idx] & CM) | (m_d[m_wp] & ~CM);
        else begin
            if (idx >= 40) idx = 0;
            exp = (m_s[idx] & SM) | (m_d[m_wp] & ~SM);
        end
        chk(req, rd_data, exp);
        cyc(0, 0, '0, '0, 0, 0, 0, '0, 1, tg);
    endtask

    task automatic t_reset();
        rd_chk(0, "R1 color after reset");
        load(16'h0000);
        rd_chk(1, "R1 scroll after reset");
        chk("R1 zero value", rd_data, 16'h0000);
    endtask

    task automatic t_color();
        step_size = 8'd0;
        push(0, 16'h0010, 16'hFFFF, 0, 1);
        drain();
        load(16'h0011);
        rd_chk(0, "R4 color odd address same word");
        push(0, 16'h007E, 16'h0AB5, 0, 0);
        drain();
        load(16'h007E);
        rd_chk(0, "R4 color last word");
        load(16'h00FE);
        rd_chk(0, "R4 color index masked to 63");
    endtask

    task automatic t_stale();
        push(0, 16'h0002, 16'hF000, 0, 0);
        push(0, 16'h0004, 16'hA111, 0, 0);
        push(1, 16'h0002, 16'h5F0F, 0, 0);
        drain();
        load(16'h0002);
        rd_chk(0, "R5 stale upper bits on color read");
        load(16'h0002);
        rd_chk(1, "R7 stale dirty bits on scroll read");
    endtask

    task automatic t_hold();
        push(0, 16'h0030, 16'h0EEE, 0, 0);
        cyc(0, 0, '0, '0, 0, 0, 0, '0, 0, 0);
        load(16'h0030);
        rd_chk(0, "R2 no commit without slot");
        drain();
        load(16'h0030);
        rd_chk(0, "R2 commit after slot granted");
    endtask

    task automatic t_scroll();
        push(1, 16'h0000, 16'h1234, 0, 0);
        push(1, 16'h004E, 16'h07FF, 0, 0);
        drain();
        load(16'h004E);
        rd_chk(1, "R7 scroll last entry");
        load(16'h0050);
        rd_chk(1, "R7 index 40 aliases entry 0");
        load(16'h007E);
        rd_chk(1, "R7 index 63 aliases entry 0");
        push(1, 16'h0050, 16'h0555, 0, 1);
        drain();
        load(16'h0000);
        rd_chk(1, "R6 out-of-range write discarded, entry 0 kept");
        load(16'h0050);
        rd_chk(1, "R6 alias still shows entry 0");
    endtask

    task automatic t_fill();
        push(0, 16'h0100, 16'h0246, 0, 0);
        push(0, 16'h0102, 16'h0888, 0, 0);
        push(0, 16'h0104, 16'h0CCC, 0, 0);
        drain();
        push(0, 16'h0006, 16'h0AAA, 1, 0);
        drain();
        load(16'h0006);
        rd_chk(0, "R8 color fill stores stale slot");
        push(1, 16'h0010, 16'h0001, 1, 0);
        drain();
        load(16'h0010);
        rd_chk(1, "R8 scroll fill stores stale slot");
    endtask

    task automatic t_full();
        push(0, 16'h0040, 16'h0002, 0, 0);
        push(0, 16'h0042, 16'h0004, 0, 0);
        push(0, 16'h0040, 16'h0008, 0, 0);
        push(0, 16'h0046, 16'h0020, 0, 0);
        push(0, 16'h0048, 16'h0222, 0, 0);
        drain();
        load(16'h0040);
        rd_chk(0, "R2 oldest first, later write wins");
        load(16'h0046);
        rd_chk(0, "R2 fourth entry committed");
        load(16'h0048);
        rd_chk(0, "R3 push on full queue dropped");
    endtask

    task automatic t_addr();
        push(0, 16'h0002, 16'h0E0E, 0, 1);
        drain();
        step_size = 8'd4;
        load(16'hFFFE);
        rd_chk(0, "R9 read before wrap");
        rd_chk(0, "R9 address wraps to word 1");
        step_size = 8'hFF;
        load(16'h0000);
        rd_chk(0, "R9 read at zero");
        rd_chk(0, "R9 step zero-extended");
        step_size = 8'd2;
        cyc(0, 0, '0, '0, 0, 0, 1, 16'h0006, 1, 0);
        rd_chk(0, "R10 load wins over strobe");
        rd_chk(0, "R11 combinational read after step");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_c[i] = '0;
        for (int i = 0; i < 40; i++) m_s[i] = '0;
        for (int i = 0; i < 4; i++) begin
            m_d[i] = '0; m_a[i] = '0; m_t[i] = 0; m_f[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_color();
        t_stale();
        t_hold();
        t_scroll();
        t_fill();
        t_full();
        t_addr();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule